// File: doc/BRIEF.md
# Accumulator Processor Core with Return Stack

A small 16-bit processor that works on whole words only. It has one accumulator, a carry flag, a zero flag, a 12-bit program counter and a return-address stack of eight entries held in registers. It talks to one synchronous single-port memory. The core drives an address, write data and a write strobe. The read data for an address comes back on the clock edge after that address was presented. Every instruction word has the same layout: an opcode, an indirect bit, and a 12-bit direct address field.

Only arithmetic, logic and store operations can use the indirect bit. When it is set, the direct field names a memory word, and that word holds the full 16-bit operand address. Data can therefore live anywhere in a 64K-word space, while code stays inside the first 4K words. Subroutine calls and the single interrupt input both save their return address on the internal stack. The two conditional jumps clear the flag they test.

Top module: `acc_cpu`

## Requirements
- R1: While `rst_ni` is low, `mem_we_o` is 0 and `mem_addr_o` is 0. After release, the first instruction is fetched from address 0 with the accumulator, carry and zero all cleared and interrupts enabled.
- R2: Instruction word encoding: bits 15..13 hold the opcode (0 ADD, 1 NOR, 2 STO, 3 JSR, 4 JNZ, 5 JNC, 6 RTI, 7 RTS), bit 12 is the indirect bit, and bits 11..0 are the direct address.
- R3: ADD sets the accumulator to accumulator plus operand, modulo 2^16. Carry takes bit 16 of the sum. Zero is set when the 16-bit result is 0.
- R4: NOR sets the accumulator to the bitwise NOR of accumulator and operand. It updates zero and leaves carry unchanged.
- R5: STO writes the accumulator to the effective address. The accumulator and the flags are left unchanged.
- R6: When the indirect bit is set on ADD, NOR or STO, the effective address is the full 16-bit word read from the direct address. Otherwise it is the zero-extended direct field.
- R7: JNZ branches to the direct field when zero is 0 and always clears zero. JNC branches when carry is 0 and always clears carry. When the branch is not taken, execution continues at the next word.
- R8: JSR pushes the address of the following word and jumps to the direct field. RTS pops the stack into the program counter. Calls nest correctly up to 8 levels deep.
- R9: A ninth push without an intervening pop overwrites the oldest entry. The 8 most recent return addresses stay intact.
- R10: With interrupts enabled, a high `irq_i` seen between instructions pushes the address of the next instruction, clears the enable and continues at `IRQ_VEC` (default 0x008). While the enable is clear, `irq_i` is ignored.
- R11: RTI pops the stack into the program counter and re-enables interrupts.
- R12: The program counter is 12 bits wide and wraps from 0xFFF to 0x000, so instructions are fetched only from the 4K-word space.
- R13: Jump-type instructions ignore the indirect bit and use the direct field as the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 1 | Interrupt request, level sensitive |
| mem_addr_o | output | ADDR_W (16) | Word address to memory |
| mem_wdata_o | output | DATA_W (16) | Write data to memory |
| mem_we_o | output | 1 | Write strobe |
| mem_rdata_i | input | DATA_W (16) | Read data, valid the cycle after the address |

## Verification
The hardest case to reach is stack overflow. Producing it takes nine nested calls with no return in between, and the outcome can only be seen in where the return chain eventually goes. The bench builds a chain of subroutines. Each level records a marker in memory on its way back, so a lost outermost entry shows up as a missing marker from the main program while the markers from the eight inner levels are still present. Interrupt masking is reached by holding `irq_i` high for longer than the entry sequence takes but shorter than the handler. The handler's per-entry increment then shows exactly one entry per pulse.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_NOR = 3'd1,
    OP_STO = 3'd2,
    OP_JSR = 3'd3,
    OP_JNZ = 3'd4,
    OP_JNC = 3'd5,
    OP_RTI = 3'd6,
    OP_RTS = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    S_FETCH,
    S_DEC,
    S_PTR,
    S_ALU
  } state_e;

  typedef struct packed {
    op_e         op;
    logic        ind;
    logic [11:0] dir;
  } instr_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  op_e               op_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              c_i,
  output logic [DATA_W-1:0] res_o,
  output logic              c_o,
  output logic              z_o
);

  logic [DATA_W:0] sum;

  always_comb begin
    sum = {1'b0, acc_i} + {1'b0, opnd_i};
    if (op_i == OP_NOR) begin
      res_o = ~(acc_i | opnd_i);
      c_o   = c_i;
    end else begin
      res_o = sum[DATA_W-1:0];
      c_o   = sum[DATA_W];
    end
    z_o = (res_o == '0);
  end

endmodule

// File: rtl/acc_ret_stack.sv
module acc_ret_stack #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned W     = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o
);

  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [IW-1:0] ptr_q;
  logic [W-1:0]  ent_q [DEPTH];
  logic [IW-1:0] top_idx;

  // circular: overflow overwrites oldest, underflow just wraps
  assign top_idx = ptr_q - IW'(1);
  assign top_o   = ent_q[top_idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else if (push_i) begin
      ent_q[ptr_q] <= data_i;
      ptr_q        <= ptr_q + IW'(1);
    end else if (pop_i) begin
      ptr_q <= top_idx;
    end
  end

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int unsigned    DATA_W      = 16,
  parameter int unsigned    ADDR_W      = 16,
  parameter int unsigned    PC_W        = 12,
  parameter int unsigned    STACK_DEPTH = 8,
  parameter logic [PC_W-1:0] IRQ_VEC    = 12'h008
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              irq_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);

  state_e            state_q;
  logic [PC_W-1:0]   pc_q, pc_inc, stk_top, push_data;
  logic [DATA_W-1:0] acc_q, alu_res;
  logic              c_q, z_q, ie_q, alu_c, alu_z;
  instr_t            ir_q, ir_cur;
  logic              irq_take, push, pop;
  logic [ADDR_W-1:0] dir_ext, pc_ext;

  assign ir_cur   = (state_q == S_DEC) ? instr_t'(mem_rdata_i[15:0]) : ir_q;
  assign pc_inc   = pc_q + PC_W'(1);
  assign dir_ext  = ADDR_W'(ir_cur.dir);
  assign pc_ext   = ADDR_W'(pc_q);
  assign irq_take = (state_q == S_FETCH) && irq_i && ie_q;

  acc_alu #(.DATA_W(DATA_W)) u_alu (
    .op_i  (ir_q.op),
    .acc_i (acc_q),
    .opnd_i(mem_rdata_i),
    .c_i   (c_q),
    .res_o (alu_res),
    .c_o   (alu_c),
    .z_o   (alu_z)
  );

  acc_ret_stack #(.DEPTH(STACK_DEPTH), .W(PC_W)) u_stack (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .push_i(push),
    .pop_i (pop),
    .data_i(push_data),
    .top_o (stk_top)
  );

  always_comb begin
    mem_addr_o  = pc_ext;
    mem_we_o    = 1'b0;
    mem_wdata_o = acc_q;
    push        = 1'b0;
    pop         = 1'b0;
    push_data   = pc_inc;
    case (state_q)
      S_FETCH: begin
        if (irq_take) begin
          push      = 1'b1;
          push_data = pc_q;
        end
      end
      S_DEC: begin
        case (ir_cur.op)
          OP_ADD, OP_NOR: mem_addr_o = dir_ext;
          OP_STO: begin
            mem_addr_o = dir_ext;
            mem_we_o   = !ir_cur.ind;
          end
          OP_JSR:         push = 1'b1;
          OP_RTS, OP_RTI: pop  = 1'b1;
          default: ;
        endcase
      end
      S_PTR: begin
        // pointer word just arrived: it is the effective address
        mem_addr_o = mem_rdata_i[ADDR_W-1:0];
        mem_we_o   = (ir_q.op == OP_STO);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      acc_q   <= '0;
      c_q     <= 1'b0;
      z_q     <= 1'b0;
      ie_q    <= 1'b1;
      ir_q    <= '0;
    end else begin
      case (state_q)
        S_FETCH: begin
          if (irq_take) begin
            pc_q <= IRQ_VEC;
            ie_q <= 1'b0;
          end else begin
            state_q <= S_DEC;
          end
        end
        S_DEC: begin
          ir_q    <= ir_cur;
          state_q <= S_FETCH;
          case (ir_cur.op)
            OP_ADD, OP_NOR: begin
              pc_q    <= pc_inc;
              state_q <= ir_cur.ind ? S_PTR : S_ALU;
            end
            OP_STO: begin
              pc_q    <= pc_inc;
              state_q <= ir_cur.ind ? S_PTR : S_FETCH;
            end
            OP_JSR: pc_q <= ir_cur.dir;
            OP_JNZ: begin
              pc_q <= z_q ? pc_inc : ir_cur.dir;
              z_q  <= 1'b0;
            end
            OP_JNC: begin
              pc_q <= c_q ? pc_inc : ir_cur.dir;
              c_q  <= 1'b0;
            end
            OP_RTI: begin
              pc_q <= stk_top;
              ie_q <= 1'b1;
            end
            OP_RTS: pc_q <= stk_top;
            default: ;
          endcase
        end
        S_PTR: begin
          state_q <= (ir_q.op == OP_STO) ? S_FETCH : S_ALU;
        end
        S_ALU: begin
          acc_q   <= alu_res;
          c_q     <= alu_c;
          z_q     <= alu_z;
          state_q <= S_FETCH;
        end
        default: state_q <= S_FETCH;
      endcase
    end
  end

endmodule

// File: rtl/acc_cpu_chk.sv
module acc_cpu_chk
  import acc_cpu_pkg::*;
#(
  parameter int unsigned     DATA_W  = 16,
  parameter int unsigned     PC_W    = 12,
  parameter logic [PC_W-1:0] IRQ_VEC = 12'h008
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_i,
  input logic              mem_we_o,
  input logic [2:0]        rd_op_i,
  input state_e            state_q,
  input instr_t            ir_q,
  input logic [PC_W-1:0]   pc_q,
  input logic [DATA_W-1:0] acc_q,
  input logic              c_q,
  input logic              z_q,
  input logic              ie_q
);

  // R5: a store finishes its instruction
  a_r5_store_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> (state_q == S_FETCH));

  a_r7_jnz_clears_z: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && rd_op_i == OP_JNZ) |=> !z_q);

  a_r7_jnc_clears_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && rd_op_i == OP_JNC) |=> !c_q);

  a_r3_add_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ALU && ir_q.op == OP_ADD) |=> (z_q == (acc_q == '0)));

  a_r4_nor_keeps_c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_ALU && ir_q.op == OP_NOR) |=> $stable(c_q));

  a_r10_irq_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_FETCH && irq_i && ie_q) |=>
      (pc_q == IRQ_VEC && !ie_q && state_q == S_FETCH));

  a_r11_rti_enables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DEC && rd_op_i == OP_RTI) |=> ie_q);

endmodule

bind acc_cpu acc_cpu_chk #(
  .DATA_W (DATA_W),
  .PC_W   (PC_W),
  .IRQ_VEC(IRQ_VEC)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .irq_i   (irq_i),
  .mem_we_o(mem_we_o),
  .rd_op_i (mem_rdata_i[15:13]),
  .state_q (state_q),
  .ir_q    (ir_q),
  .pc_q    (pc_q),
  .acc_q   (acc_q),
  .c_q     (c_q),
  .z_q     (z_q),
  .ie_q    (ie_q)
);

// File: tb/acc_cpu_tb.sv
module acc_cpu_tb;
  import acc_cpu_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq = 1'b0;
  logic [15:0] addr, wdata, rdata;
  logic        we;
  logic        clr = 1'b0, ld = 1'b0, hi_seen;
  logic [11:0] ld_a = '0;
  logic [15:0] ld_d = '0;
  logic [15:0] mem [4096];
  int          total = 0, bad = 0;

  always #4 clk = ~clk;

  acc_cpu u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .irq_i      (irq),
    .mem_addr_o (addr),
    .mem_wdata_o(wdata),
    .mem_we_o   (we),
    .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (clr) begin
      for (int i = 0; i < 4096; i++) mem[i] <= 16'hDEAD;
      hi_seen <= 1'b0;
    end else if (ld) begin
      mem[ld_a] <= ld_d;
    end else if (we) begin
      mem[addr[11:0]] <= wdata;
      if (addr == 16'hA123 && wdata == 16'h0042) hi_seen <= 1'b1;
    end
    rdata <= mem[addr[11:0]];
  end

  function automatic logic [15:0] ins(input logic [2:0] op, input logic ind, input logic [11:0] a);
    return {op, ind, a};
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic prep();
    rst_n = 1'b0;
    irq   = 1'b0;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk);
    ld = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk);
    ld = 1'b0;
  endtask

  task automatic halt(input logic [11:0] a);
    put(a, ins(OP_JNC, 1'b0, a));
    put(a + 12'd1, ins(OP_JNC, 1'b0, a + 12'd1));
  endtask

  task automatic go(input int n);
    @(negedge clk) rst_n = 1'b1;
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    prep();
    put(12'h100, 16'h0003);
    put(12'h000, ins(OP_ADD, 1'b0, 12'h100));
    put(12'h001, ins(OP_STO, 1'b0, 12'h200));
    put(12'h002, ins(OP_JNC, 1'b0, 12'h000));
    chk("R1 we in reset", {15'd0, we}, 16'h0000);
    chk("R1 addr in reset", addr, 16'h0000);
    go(23);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 we after mid-run reset", {15'd0, we}, 16'h0000);
    chk("R1 addr after mid-run reset", addr, 16'h0000);
    chk("R1 program ran before reset", {15'd0, mem[12'h200] != 16'hDEAD}, 16'h0001);
  endtask

  task automatic t_add();
    prep();
    put(12'h100, 16'h1234); put(12'h101, 16'h0F0F); put(12'h102, 16'hDEBD);
    put(12'h000, ins(OP_ADD, 1'b0, 12'h100));
    put(12'h001, ins(OP_ADD, 1'b0, 12'h101));
    put(12'h002, ins(OP_STO, 1'b0, 12'h200));
    put(12'h003, ins(OP_ADD, 1'b0, 12'h102));
    put(12'h004, ins(OP_JNC, 1'b0, 12'h030));
    put(12'h005, ins(OP_STO, 1'b0, 12'h201));
    halt(12'h006);
    put(12'h030, ins(OP_STO, 1'b0, 12'h202));
    halt(12'h031);
    go(60);
    chk("R3 R2 add sum", mem[12'h200], 16'h2143);
    chk("R3 wrap result", mem[12'h201], 16'h0000);
    chk("R3 carry set blocks JNC", mem[12'h202], 16'hDEAD);
    chk("R5 operand untouched", mem[12'h100], 16'h1234);
  endtask

  task automatic t_flags();
    prep();
    put(12'h100, 16'hFFFF); put(12'h101, 16'h0001); put(12'h102, 16'h0005);
    put(12'h103, 16'h00AA); put(12'h104, 16'h00BB);
    put(12'h000, ins(OP_ADD, 1'b0, 12'h100));
    put(12'h001, ins(OP_ADD, 1'b0, 12'h101));
    put(12'h002, ins(OP_STO, 1'b0, 12'h200));
    put(12'h003, ins(OP_JNC, 1'b0, 12'h020));
    put(12'h004, ins(OP_JNZ, 1'b0, 12'h030));
    put(12'h005, ins(OP_JNZ, 1'b0, 12'h050));
    put(12'h006, ins(OP_ADD, 1'b0, 12'h104));
    put(12'h007, ins(OP_STO, 1'b0, 12'h201));
    halt(12'h008);
    put(12'h020, ins(OP_ADD, 1'b0, 12'h103));
    put(12'h021, ins(OP_STO, 1'b0, 12'h203));
    halt(12'h022);
    put(12'h030, ins(OP_ADD, 1'b0, 12'h104));
    put(12'h031, ins(OP_STO, 1'b0, 12'h203));
    halt(12'h032);
    put(12'h050, ins(OP_JNC, 1'b0, 12'h040));
    put(12'h051, ins(OP_STO, 1'b0, 12'h203));
    halt(12'h052);
    put(12'h040, ins(OP_ADD, 1'b0, 12'h102));
    put(12'h041, ins(OP_JNZ, 1'b0, 12'h048));
    put(12'h042, ins(OP_ADD, 1'b0, 12'h103));
    put(12'h043, ins(OP_STO, 1'b0, 12'h202));
    halt(12'h044);
    put(12'h048, ins(OP_STO, 1'b0, 12'h201));
    halt(12'h049);
    go(80);
    chk("R3 zero result", mem[12'h200], 16'h0000);
    chk("R7 flags cleared by jumps, path ok", mem[12'h201], 16'h0005);
    chk("R7 JNZ taken on clear zero", mem[12'h202], 16'hDEAD);
    chk("R7 untaken jumps fall through", mem[12'h203], 16'hDEAD);
  endtask

  task automatic t_nor();
    prep();
    put(12'h100, 16'hFFFF); put(12'h101, 16'h0001); put(12'h102, 16'h00F0);
    put(12'h103, 16'hFFFF); put(12'h104, 16'h0007);
    put(12'h000, ins(OP_ADD, 1'b0, 12'h100));
    put(12'h001, ins(OP_ADD, 1'b0, 12'h101));
    put(12'h002, ins(OP_NOR, 1'b0, 12'h102));
    put(12'h003, ins(OP_STO, 1'b0, 12'h200));
    put(12'h004, ins(OP_JNC, 1'b0, 12'h030));
    put(12'h005, ins(OP_NOR, 1'b0, 12'h103));
    put(12'h006, ins(OP_STO, 1'b0, 12'h201));
    put(12'h007, ins(OP_JNZ, 1'b0, 12'h030));
    put(12'h008, ins(OP_ADD, 1'b0, 12'h104));
    put(12'h009, ins(OP_STO, 1'b0, 12'h202));
    halt(12'h00A);
    put(12'h030, ins(OP_STO, 1'b0, 12'h203));
    halt(12'h031);
    go(80);
    chk("R4 nor value", mem[12'h200], 16'hFF0F);
    chk("R4 nor zero value", mem[12'h201], 16'h0000);
    chk("R4 nor zero flag and path", mem[12'h202], 16'h0007);
    chk("R4 carry kept through NOR", mem[12'h203], 16'hDEAD);
  endtask

  task automatic t_indirect();
    prep();
    put(12'h100, 16'h0150); put(12'h150, 16'h0042); put(12'h101, 16'hA123);
    put(12'h000, ins(OP_ADD, 1'b1, 12'h100));
    put(12'h001, ins(OP_STO, 1'b1, 12'h101));
    put(12'h002, ins(OP_STO, 1'b0, 12'h200));
    put(12'h003, ins(OP_NOR, 1'b1, 12'h100));
    put(12'h004, ins(OP_STO, 1'b0, 12'h201));
    put(12'h005, ins(OP_JNC, 1'b1, 12'h060));
    put(12'h006, ins(OP_STO, 1'b0, 12'h203));
    halt(12'h007);
    put(12'h060, ins(OP_STO, 1'b0, 12'h202));
    halt(12'h061);
    go(80);
    chk("R6 indirect add", mem[12'h200], 16'h0042);
    chk("R6 indirect store to high address", {15'd0, hi_seen}, 16'h0001);
    chk("R6 indirect nor", mem[12'h201], 16'hFFBD);
    chk("R13 jump ignores indirect bit", mem[12'h202], 16'hFFBD);
    chk("R5 pointer word untouched", mem[12'h101], 16'hA123);
  endtask

  task automatic t_calls(input int n);
    logic [11:0] a;
    prep();
    put(12'h100, 16'h0001);
    put(12'h000, ins(OP_JSR, 1'b0, 12'h010));
    put(12'h001, ins(OP_STO, 1'b0, 12'h208));
    halt(12'h002);
    for (int k = 0; k < n; k++) begin
      a = 12'h010 + 12'(3 * k);
      if (k == n - 1) begin
        put(a, ins(OP_ADD, 1'b0, 12'h100));
        put(a + 12'd1, ins(OP_RTS, 1'b0, 12'h000));
      end else begin
        put(a, ins(OP_JSR, 1'b0, a + 12'd3));
        put(a + 12'd1, ins(OP_STO, 1'b0, 12'h210 + 12'(k)));
        put(a + 12'd2, ins(OP_RTS, 1'b0, 12'h000));
      end
    end
    go(200);
    for (int k = 0; k < n - 1; k++)
      chk((n > 8) ? "R9 recent returns intact" : "R8 nested return", mem[12'h210 + 12'(k)], 16'h0001);
    if (n > 8) chk("R9 oldest entry overwritten", mem[12'h208], 16'hDEAD);
    else       chk("R8 outermost return", mem[12'h208], 16'h0001);
  endtask

  task automatic t_irq();
    prep();
    put(12'h100, 16'h0001); put(12'h101, 16'h0100);
    put(12'h000, ins(OP_ADD, 1'b0, 12'h100));
    put(12'h001, ins(OP_STO, 1'b0, 12'h200));
    put(12'h002, ins(OP_JNC, 1'b0, 12'h000));
    put(12'h008, ins(OP_ADD, 1'b0, 12'h101));
    put(12'h009, ins(OP_STO, 1'b0, 12'h202));
    put(12'h00A, ins(OP_RTI, 1'b0, 12'h000));
    go(40);
    chk("R10 no entry without request", mem[12'h202], 16'hDEAD);
    irq = 1'b1;
    repeat (6) @(negedge clk);
    irq = 1'b0;
    repeat (60) @(negedge clk);
    chk("R10 single entry while held", {8'd0, mem[12'h202][15:8]}, 16'h0001);
    chk("R10 main resumes after return", {8'd0, mem[12'h200][15:8]}, 16'h0001);
    chk("R10 main progressed past entry", {15'd0, mem[12'h200][7:0] > mem[12'h202][7:0]}, 16'h0001);
    irq = 1'b1;
    repeat (6) @(negedge clk);
    irq = 1'b0;
    repeat (60) @(negedge clk);
    chk("R11 re-enabled after RTI", {8'd0, mem[12'h202][15:8]}, 16'h0002);
  endtask

  task automatic t_wrap();
    prep();
    put(12'h100, 16'h0005);
    put(12'h000, ins(OP_JNC, 1'b0, 12'hFFE));
    put(12'hFFE, ins(OP_ADD, 1'b0, 12'h100));
    put(12'hFFF, ins(OP_STO, 1'b0, 12'h200));
    go(100);
    chk("R12 pc wraps to zero", {15'd0, mem[12'h200] >= 16'd15}, 16'h0001);
    chk("R12 accumulate steps", mem[12'h200] % 16'd5, 16'h0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_add();
    t_flags();
    t_nor();
    t_indirect();
    t_calls(8);
    t_calls(9);
    t_irq();
    t_wrap();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule